// File: doc/BRIEF.md
# Robbed-Bit Signaling Supervisor

This block recovers the per-channel ABCD signaling that T1 channel banks carry in the least significant bit of every channel during the signaling frames of a multiframe. It works on a system-side bit stream that already carries channel, bit and frame indices. For every channel it keeps one presented signaling word, and shows the word of the channel that is on the stream at that moment on four outputs.

The presented words change only at the start of a multiframe. A new value can be made to repeat over several multiframes before it is taken (debouncing). Updates are held off for a set number of multiframes after a slip, and for as long as an external inhibit is held low. A freeze flag tells downstream logic when the stored signaling is not being refreshed. A ones-substitution gate marks the robbed-bit positions, so that a downstream stage can overwrite them in the outgoing data.

Top module: `rbs_supervisor`

## Requirements
- R1: With `ext_mode`=1 (24-frame multiframe) the bit at `bit_idx`=7 of each channel is captured as A in frame index 5, B in 11, C in 17 and D in 23 (frame index = frame number minus one). The four values of a channel form one word.
- R2: With `ext_mode`=0 (12-frame multiframe) A is taken from frame index 5 and B from 11. C and D present the A and B that were captured in the multiframe before.
- R3: One ABCD word is stored per channel. The outputs show the word of the channel on `chan_idx` with no delay. A stored word changes only on the multiframe start cycle, which is a cycle with `bit_vld`=1 and `frame_idx`, `chan_idx` and `bit_idx` all 0.
- R4: With `mode_sel` 00 or 11 there is no debouncing. A word captured in one multiframe is presented from the next multiframe start, unless a freeze is active.
- R5: With `mode_sel` 01 a changed word must be captured identically in 2 consecutive multiframes before it is presented. With 10 it must be captured in 3 consecutive multiframes when `ext_mode`=1, and in 5 when `ext_mode`=0.
- R6: A cycle with `slip_in`=1 blocks the following multiframe starts from updating: 1 of them for `mode_sel` 00 or 11, and 2 for 01 or 10.
- R7: While `inhibit_n` is 0 every multiframe start is blocked. After it returns to 1, the freeze length of R6 applies before updates resume.
- R8: `freeze_o` rises in the cycle after a slip or a low `inhibit_n`. It falls in the cycle after the first multiframe start at which updates are allowed again.
- R9: At the multiframe start that ends a freeze, the repeat count a word needs is capped at 2.
- R10: `ones_gate` is 1 exactly when `mode_sel`=11, `bit_vld`=1 and `bit_idx`=7, in a frame that carries signaling for the current framing mode.
- R11: After reset every stored word is 0 and `freeze_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | A stream bit is present this cycle |
| ser_in | input | 1 | Stream data bit |
| chan_idx | input | CH_W | Channel index of the current bit (0-based) |
| bit_idx | input | 3 | Bit index within the channel, 7 is the LSB |
| frame_idx | input | 5 | Frame index within the multiframe (0-based) |
| ext_mode | input | 1 | 1 = 24-frame multiframe, 0 = 12-frame multiframe |
| mode_sel | input | 2 | Debounce and freeze mode |
| slip_in | input | 1 | Slip event pulse from the elastic store |
| inhibit_n | input | 1 | Active-low update inhibit |
| sig_a | output | 1 | Presented A bit of the current channel |
| sig_b | output | 1 | Presented B bit of the current channel |
| sig_c | output | 1 | Presented C bit of the current channel |
| sig_d | output | 1 | Presented D bit of the current channel |
| freeze_o | output | 1 | Signaling updates are being held off |
| ones_gate | output | 1 | Robbed-bit position to be overwritten with one |

## Verification
Distinct ABCD words per channel, changed between multiframes, show whether each frame slot lands in the right output and the right channel. Repeating a word for a chosen number of multiframes and then changing it shows the exact debounce depth in each mode. Switching to 12-frame framing after known A and B values shows that C and D carry over the previous multiframe. Slips placed mid-multiframe, inhibit held over several multiframes, and a new word that arrives during a freeze show the blocking length, when the freeze flag is raised and dropped, and the capped count at release.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int CNT_W   = 3;
    localparam int FRAME_W = 5;
    localparam int BIT_W   = 3;
    localparam logic [BIT_W-1:0] LSB_POS = 3'd7;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } sig_word_t;

    typedef enum logic [1:0] {
        MODE_PLAIN    = 2'b00,
        MODE_INT2     = 2'b01,
        MODE_INT_LONG = 2'b10,
        MODE_ONES     = 2'b11
    } sup_mode_e;

    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_A,
        SLOT_B,
        SLOT_C,
        SLOT_D
    } slot_e;

    // Which signaling bit (if any) a frame carries for the given framing mode
    function automatic slot_e slot_of(logic [FRAME_W-1:0] frame, logic ext);
        slot_e s;
        case (frame)
            5'd5:    s = SLOT_A;
            5'd11:   s = SLOT_B;
            5'd17:   s = ext ? SLOT_C : SLOT_NONE;
            5'd23:   s = ext ? SLOT_D : SLOT_NONE;
            default: s = SLOT_NONE;
        endcase
        return s;
    endfunction

    // Number of identical consecutive captures needed before acceptance
    function automatic logic [CNT_W-1:0] need_count(sup_mode_e m, logic ext, logic limited);
        logic [CNT_W-1:0] n;
        case (m)
            MODE_INT2:     n = CNT_W'(2);
            MODE_INT_LONG: n = ext ? CNT_W'(3) : CNT_W'(5);
            default:       n = CNT_W'(1);
        endcase
        if (limited && (n > CNT_W'(2)))
            n = CNT_W'(2);
        return n;
    endfunction

    // Number of multiframe starts blocked after a freeze trigger
    function automatic logic [1:0] freeze_len(sup_mode_e m);
        logic [1:0] l;
        case (m)
            MODE_INT2, MODE_INT_LONG: l = 2'd2;
            default:                  l = 2'd1;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/rbs_capture.sv
module rbs_capture
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bit_vld,
    input  logic                     ser_in,
    input  logic [CH_W-1:0]          chan_idx,
    input  logic [BIT_W-1:0]         bit_idx,
    input  logic [FRAME_W-1:0]       frame_idx,
    input  logic                     ext_mode,
    input  logic                     mf_start,
    output sig_word_t [NUM_CH-1:0]   cand_words
);

    slot_e slot;
    logic  lsb_hit;

    assign slot    = slot_of(frame_idx, ext_mode);
    assign lsb_hit = bit_vld && (bit_idx == LSB_POS) && (slot != SLOT_NONE);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        sig_word_t  cap_q;
        logic [1:0] prev_ab_q;
        logic       mine;
        sig_word_t  word_c;

        assign mine = lsb_hit && (chan_idx == CH_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q     <= '0;
                prev_ab_q <= '0;
            end else begin
                if (mf_start)
                    prev_ab_q <= {cap_q.a, cap_q.b};
                if (mine) begin
                    case (slot)
                        SLOT_A:  cap_q.a <= ser_in;
                        SLOT_B:  cap_q.b <= ser_in;
                        SLOT_C:  cap_q.c <= ser_in;
                        SLOT_D:  cap_q.d <= ser_in;
                        default: ;
                    endcase
                end
            end
        end

        // 12-frame framing: C/D carry the A/B of the multiframe before
        always_comb begin
            word_c = cap_q;
            if (!ext_mode) begin
                word_c.c = prev_ab_q[1];
                word_c.d = prev_ab_q[0];
            end
        end

        assign cand_words[i] = word_c;
    end

endmodule

// File: rtl/rbs_integrator.sv
module rbs_integrator
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mf_start,
    input  logic [CNT_W-1:0]        need,
    input  sig_word_t [NUM_CH-1:0]  cand_words,
    output logic [NUM_CH-1:0]       accept
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        sig_word_t        held_q;
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] cnt_nx;

        always_comb begin
            if (cand_words[i] == held_q)
                cnt_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            else
                cnt_nx = CNT_W'(1);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                held_q <= '0;
                cnt_q  <= '0;
            end else if (mf_start) begin
                held_q <= cand_words[i];
                cnt_q  <= cnt_nx;
            end
        end

        assign accept[i] = mf_start && (cnt_nx >= need);

        AST_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
            mf_start |=> (cnt_q != '0)); // R5
    end

endmodule

// File: rtl/rbs_freeze_ctl.sv
module rbs_freeze_ctl
    import rbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mf_start,
    input  logic      slip_in,
    input  logic      inhibit_n,
    input  sup_mode_e mode,
    output logic      update_en,
    output logic      freeze_o
);

    logic [1:0] frz_cnt_q;
    logic       trig;

    assign trig      = slip_in || !inhibit_n;
    assign update_en = mf_start && !trig && (frz_cnt_q == 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            frz_cnt_q <= 2'd0;
            freeze_o  <= 1'b0;
        end else begin
            if (trig)
                frz_cnt_q <= freeze_len(mode);
            else if (mf_start && (frz_cnt_q != 2'd0))
                frz_cnt_q <= frz_cnt_q - 2'd1;

            if (trig)
                freeze_o <= 1'b1;
            else if (update_en)
                freeze_o <= 1'b0;
        end
    end

    AST_FREEZE_RISE: assert property (@(posedge clk) disable iff (rst)
        (slip_in || !inhibit_n) |=> freeze_o); // R8

    AST_FREEZE_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(freeze_o) |-> $past(update_en)); // R8

endmodule

// File: rtl/rbs_supervisor.sv
module rbs_supervisor
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_vld,
    input  logic            ser_in,
    input  logic [CH_W-1:0] chan_idx,
    input  logic [2:0]      bit_idx,
    input  logic [4:0]      frame_idx,
    input  logic            ext_mode,
    input  logic [1:0]      mode_sel,
    input  logic            slip_in,
    input  logic            inhibit_n,
    output logic            sig_a,
    output logic            sig_b,
    output logic            sig_c,
    output logic            sig_d,
    output logic            freeze_o,
    output logic            ones_gate
);

    sup_mode_e              mode;
    logic                   mf_start;
    logic                   update_en;
    logic [CNT_W-1:0]       need;
    logic [NUM_CH-1:0]      accept;
    sig_word_t [NUM_CH-1:0] cand_words;
    sig_word_t [NUM_CH-1:0] out_q;
    sig_word_t              sel_word;

    assign mode     = sup_mode_e'(mode_sel);
    assign mf_start = bit_vld && (frame_idx == '0) && (chan_idx == '0) && (bit_idx == '0);
    assign need     = need_count(mode, ext_mode, freeze_o);

    rbs_capture #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_capture (
        .clk        (clk),
        .rst        (rst),
        .bit_vld    (bit_vld),
        .ser_in     (ser_in),
        .chan_idx   (chan_idx),
        .bit_idx    (bit_idx),
        .frame_idx  (frame_idx),
        .ext_mode   (ext_mode),
        .mf_start   (mf_start),
        .cand_words (cand_words)
    );

    rbs_integrator #(
        .NUM_CH (NUM_CH)
    ) u_integrator (
        .clk        (clk),
        .rst        (rst),
        .mf_start   (mf_start),
        .need       (need),
        .cand_words (cand_words),
        .accept     (accept)
    );

    rbs_freeze_ctl u_freeze (
        .clk       (clk),
        .rst       (rst),
        .mf_start  (mf_start),
        .slip_in   (slip_in),
        .inhibit_n (inhibit_n),
        .mode      (mode),
        .update_en (update_en),
        .freeze_o  (freeze_o)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst)
                out_q[i] <= '0;
            else if (update_en && accept[i])
                out_q[i] <= cand_words[i];
        end
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan_idx == CH_W'(i))
                sel_word = out_q[i];
        end
    end

    assign sig_a = sel_word.a;
    assign sig_b = sel_word.b;
    assign sig_c = sel_word.c;
    assign sig_d = sel_word.d;

    assign ones_gate = (mode == MODE_ONES) && bit_vld && (bit_idx == LSB_POS)
                       && (slot_of(frame_idx, ext_mode) != SLOT_NONE);

    AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
        !mf_start |=> $stable(out_q)); // R3

    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mf_start && !inhibit_n) |=> $stable(out_q)); // R7

    AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mf_start && slip_in) |=> $stable(out_q)); // R6

endmodule

// File: tb/rbs_supervisor_test.sv
`timescale 1ns/1ps
module rbs_supervisor_test;

    localparam int NCH      = 4;
    localparam int CW       = 2;
    localparam int WD_LIMIT = 150000;

    typedef logic [3:0] wvec_t [NCH];

    localparam wvec_t P1 = '{4'hA, 4'h5, 4'hF, 4'h3};
    localparam wvec_t P2 = '{4'h6, 4'h9, 4'h0, 4'hC};
    localparam wvec_t P3 = '{4'h7, 4'hB, 4'h4, 4'hE};
    localparam wvec_t P4 = '{4'hC, 4'h3, 4'h9, 4'h6};
    localparam wvec_t P5 = '{4'h1, 4'hE, 4'hD, 4'h2};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          bit_vld = 1'b0;
    logic          ser_in = 1'b0;
    logic [CW-1:0] chan_idx = '0;
    logic [2:0]    bit_idx = '0;
    logic [4:0]    frame_idx = '0;
    logic          ext_mode = 1'b1;
    logic [1:0]    mode_sel = 2'b00;
    logic          slip_in = 1'b0;
    logic          inhibit_n = 1'b1;
    logic          sig_a, sig_b, sig_c, sig_d, freeze_o, ones_gate;

    rbs_supervisor #(.NUM_CH(NCH), .CH_W(CW)) uut (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .ser_in(ser_in),
        .chan_idx(chan_idx), .bit_idx(bit_idx), .frame_idx(frame_idx),
        .ext_mode(ext_mode), .mode_sel(mode_sel), .slip_in(slip_in),
        .inhibit_n(inhibit_n), .sig_a(sig_a), .sig_b(sig_b), .sig_c(sig_c),
        .sig_d(sig_d), .freeze_o(freeze_o), .ones_gate(ones_gate)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // stimulus control
    wvec_t pat;
    wvec_t probe_exp;
    bit    probe_on = 1'b0;
    bit    probe_frz = 1'b0;
    string probe_tag = "";

    // behavioural reference model state (word bit 3=A, 2=B, 1=C, 0=D)
    int m_cap [NCH];
    int m_prev[NCH];
    int m_held[NCH];
    int m_cnt [NCH];
    int m_out [NCH];
    int m_frz  = 0;
    bit m_flag = 1'b0;

    function automatic int slot_bit(int f, bit ext);
        if (f == 5) return 3;
        if (f == 11) return 2;
        if (ext && f == 17) return 1;
        if (ext && f == 23) return 0;
        return -1;
    endfunction

    function automatic int need_of(int m, bit ext, bit lim);
        int n;
        n = (m == 1) ? 2 : (m == 2) ? (ext ? 3 : 5) : 1;
        if (lim && n > 2) n = 2;
        return n;
    endfunction

    function automatic wvec_t sf_mix(wvec_t cur, wvec_t prv);
        wvec_t r;
        for (int i = 0; i < NCH; i++) r[i] = (cur[i] & 4'hC) | ((prv[i] >> 2) & 4'h3);
        return r;
    endfunction

    always @(posedge clk) begin : model
        bit mfs, trig, upd;
        int w, nd, sb;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_cap[i] = 0; m_prev[i] = 0; m_held[i] = 0; m_cnt[i] = 0; m_out[i] = 0;
            end
            m_frz  = 0;
            m_flag = 1'b0;
        end else begin
            mfs  = bit_vld && frame_idx == 0 && chan_idx == 0 && bit_idx == 0;
            trig = slip_in || !inhibit_n;
            upd  = mfs && !trig && m_frz == 0;
            nd   = need_of(int'(mode_sel), ext_mode, m_flag);
            if (mfs) begin
                for (int i = 0; i < NCH; i++) begin
                    w = ext_mode ? m_cap[i] : ((m_cap[i] & 12) | m_prev[i]);
                    if (w == m_held[i]) m_cnt[i] = (m_cnt[i] < 7) ? m_cnt[i] + 1 : 7;
                    else m_cnt[i] = 1;
                    m_held[i] = w;
                    if (upd && m_cnt[i] >= nd) m_out[i] = w;
                    m_prev[i] = (m_cap[i] >> 2) & 3;
                end
            end
            sb = slot_bit(int'(frame_idx), ext_mode);
            if (bit_vld && bit_idx == 7 && sb >= 0) begin
                if (ser_in) m_cap[chan_idx] = m_cap[chan_idx] | (1 << sb);
                else        m_cap[chan_idx] = m_cap[chan_idx] & ~(1 << sb);
            end
            if (trig) m_frz = (mode_sel == 2'b01 || mode_sel == 2'b10) ? 2 : 1;
            else if (mfs && m_frz > 0) m_frz = m_frz - 1;
            if (trig) m_flag = 1'b1;
            else if (upd) m_flag = 1'b0;
        end
    end

    task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [3:0] expw;
        logic       expg;
        expw = 4'(m_out[chan_idx]);
        expg = (mode_sel == 2'b11) && bit_vld && bit_idx == 3'd7
               && slot_bit(int'(frame_idx), ext_mode) >= 0;
        chk("R3", "word", {sig_a, sig_b, sig_c, sig_d}, expw);
        chk("R8", "freeze", {3'b0, freeze_o}, {3'b0, m_flag});
        chk("R10", "gate", {3'b0, ones_gate}, {3'b0, expg});
    endtask

    task automatic run_mf(input int slip_frame);
        int nf;
        int sb;
        nf = ext_mode ? 24 : 12;
        for (int f = 0; f < nf; f++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                for (int b = 0; b < 8; b++) begin
                    @(negedge clk);
                    compare_all();
                    if (probe_on && frame_idx == 5'd1 && bit_idx == 3'd1) begin
                        chk(probe_tag, "probe word", {sig_a, sig_b, sig_c, sig_d}, probe_exp[chan_idx]);
                        chk(probe_tag, "probe freeze", {3'b0, freeze_o}, {3'b0, probe_frz});
                    end
                    sb        = slot_bit(f, ext_mode);
                    bit_vld   = 1'b1;
                    frame_idx = 5'(f);
                    chan_idx  = CW'(ch);
                    bit_idx   = 3'(b);
                    ser_in    = (b == 7 && sb >= 0) ? pat[ch][sb] : (((f + ch + b) % 3) == 0);
                    slip_in   = (f == slip_frame && ch == 0 && b == 0);
                end
            end
        end
    endtask

    task automatic run_p(input wvec_t p, input int slip_f, input bit pon,
                         input string tag, input wvec_t e, input bit efrz);
        pat       = p;
        probe_on  = pon;
        probe_tag = tag;
        probe_exp = e;
        probe_frz = efrz;
        run_mf(slip_f);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            fails++;
            checks++;
            $display("FAIL R3 watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        pat = P1;
        probe_exp = P1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11", "word", {sig_a, sig_b, sig_c, sig_d}, 4'h0);
        chk("R11", "freeze", {3'b0, freeze_o}, 4'h0);
        chk("R11", "gate", {3'b0, ones_gate}, 4'h0);

        // R1 / R4: 24-frame capture, no debounce
        ext_mode = 1'b1; mode_sel = 2'b00;
        run_p(P1, -1, 0, "", P1, 0);
        run_p(P1, -1, 1, "R1", P1, 0);
        run_p(P2, -1, 1, "R4", P1, 0);
        run_p(P2, -1, 1, "R4", P2, 0);

        // R2: 12-frame framing, C/D from previous multiframe
        ext_mode = 1'b0;
        run_p(P1, -1, 0, "", P1, 0);
        run_p(P3, -1, 0, "", P1, 0);
        run_p(P3, -1, 1, "R2", sf_mix(P3, P1), 0);
        run_p(P3, -1, 1, "R2", sf_mix(P3, P3), 0);

        // R5: two-multiframe debounce
        ext_mode = 1'b1;
        run_p(P3, -1, 0, "", P3, 0);
        run_p(P3, -1, 0, "", P3, 0);
        mode_sel = 2'b01;
        run_p(P4, -1, 1, "R5", P3, 0);
        run_p(P4, -1, 1, "R5", P3, 0);
        run_p(P4, -1, 1, "R5", P4, 0);

        // R5: three-multiframe debounce in 24-frame framing
        mode_sel = 2'b10;
        run_p(P1, -1, 0, "", P4, 0);
        run_p(P1, -1, 0, "", P4, 0);
        run_p(P1, -1, 1, "R5", P4, 0);
        run_p(P1, -1, 1, "R5", P1, 0);

        // R6 / R8: slip, one blocked boundary
        mode_sel = 2'b00;
        run_p(P2, 3, 0, "", P1, 0);
        run_p(P2, -1, 1, "R6", P1, 1);
        run_p(P2, -1, 1, "R8", P2, 0);

        // R6 / R9: slip with two blocked boundaries, capped count at release
        mode_sel = 2'b10;
        run_p(P2, 3, 0, "", P2, 0);
        run_p(P5, -1, 0, "", P2, 0);
        run_p(P5, -1, 1, "R6", P2, 1);
        run_p(P5, -1, 1, "R9", P5, 0);

        // R7: inhibit held low, then released
        mode_sel = 2'b00;
        inhibit_n = 1'b0;
        run_p(P1, -1, 0, "", P5, 1);
        run_p(P1, -1, 1, "R7", P5, 1);
        run_p(P1, -1, 1, "R7", P5, 1);
        inhibit_n = 1'b1;
        run_p(P1, -1, 1, "R7", P5, 1);
        run_p(P1, -1, 1, "R7", P1, 0);

        // R10 / R4: ones-substitution mode
        mode_sel = 2'b11;
        run_p(P2, -1, 0, "", P1, 0);
        run_p(P2, -1, 1, "R4", P2, 0);
        ext_mode = 1'b0;
        run_p(P3, -1, 0, "", P2, 0);
        run_p(P3, 2, 0, "", P2, 0);

        // R5: five-multiframe debounce in 12-frame framing (model compare)
        mode_sel = 2'b10;
        for (int k = 0; k < 7; k++) run_p(P4, -1, 0, "", P4, 0);
        mode_sel = 2'b01;
        run_p(P5, 4, 0, "", P5, 0);
        run_p(P5, -1, 0, "", P5, 0);
        run_p(P5, -1, 0, "", P5, 0);

        @(negedge clk);
        compare_all();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule